// File: doc/BRIEF.md
# Three-Wide Register Renamer

This block renames a group of three instructions in a single clock cycle. Each slot of the group names two logical source registers and, optionally, one logical destination. The block reads the current logical-to-physical mapping for every source, hands each destination a fresh physical register from a FIFO free list, and writes the new mappings into the table at the clock edge. It also reports, for each slot, the physical register its destination was mapped to before the slot. A later stage frees that register.

Dependencies inside the group are settled in the same cycle. If a later slot reads a register that an earlier slot writes, it receives the earlier slot's new physical tag rather than the stale table entry. A run of writes to one logical register therefore receives a run of distinct physical tags. All tags are fixed at rename time, before any result value exists.

Physical registers come back through a one-tag-per-cycle free input. The renamed tags are combinational outputs of the current table and free-list state. The table and free list change only at the clock edge that takes a group.

Top module: `reg_renamer`

## Requirements
- R1: When `inValid` is high and the free list holds at least GROUP entries, `accept` is high, and every slot's tags are valid in that same cycle.
- R2: On an accepted group, each slot with `dstEn` set receives a distinct physical tag. Tags are taken from the head of the free list, in slot order from slot 0 upward.
- R3: A source that matches the destination of an earlier enabled slot in the same group takes the youngest such slot's new tag; otherwise it takes the table entry. For three slots that each read and write logical 1 just after reset, the sources get 1, 8, 9, the destinations get 8, 9, 10, and logical 1 then maps to 10.
- R4: `oldPhys` of a slot is the mapping its destination had just before that slot, including writes by earlier slots in the group.
- R5: When several slots of an accepted group write the same logical register, the highest-numbered slot sets the table entry seen from the next cycle.
- R6: With fewer than GROUP free entries, `accept` is low, no tag is allocated and the table keeps its contents.
- R7: A slot with `dstEn` low takes no physical register and changes no table entry.
- R8: After reset, logical register i maps to physical register i, and the free list holds NUM_LOG to NUM_PHYS-1 in ascending order.
- R9: A tag presented on `freeTag` with `freeEn` high joins the tail of the free list. It is handed out after the tags already on the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A group is presented |
| dstEn | input | GROUP | Per-slot destination enable, bit i for slot i |
| dstLog | input | GROUP*LW | Logical destinations, slot i at bits [i*LW +: LW] |
| srcALog | input | GROUP*LW | First logical sources, packed per slot |
| srcBLog | input | GROUP*LW | Second logical sources, packed per slot |
| freeEn | input | 1 | Return one physical tag this cycle |
| freeTag | input | PW | Physical tag returned |
| accept | output | 1 | Group taken at the coming edge |
| srcAPhys | output | GROUP*PW | Renamed first sources, packed per slot |
| srcBPhys | output | GROUP*PW | Renamed second sources, packed per slot |
| dstPhys | output | GROUP*PW | Newly allocated destination tags, packed per slot |
| oldPhys | output | GROUP*PW | Prior mapping of each slot's destination |

## Verification
The renamed tags, `oldPhys` and `accept` are combinational, so they are due in the cycle the group is presented. The bench drives inputs on the falling edge and samples one nanosecond later, well before the rising edge that commits the group. Table updates, allocation and freed tags take effect at that rising edge. The bench observes them through the lookups of the following group, with its reference model advanced right after the edge. A stall is confirmed by the unchanged lookups and tags of the group that follows it.

// File: rtl/rename_pkg.sv
package rename_pkg;
  // Strobes from control to the datapath pieces
  typedef struct packed {
    logic fire;      // group is taken at this edge
    logic pushFree;  // freed tag is appended at this edge
  } renStrobe_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl import rename_pkg::*; #(
  parameter int GROUP = 3,
  parameter int CW    = 4
) (
  input  logic             inValid,
  input  logic             freeEn,
  input  logic [GROUP-1:0] dstEn,
  input  logic [CW-1:0]    freeCount,
  output renStrobe_t       strb,
  output logic [CW-1:0]    allocCnt
);
  // A group needs room for a full set of destinations, whatever it asks for
  always_comb begin
    strb.fire     = inValid && (freeCount >= CW'(GROUP));
    strb.pushFree = freeEn;
    allocCnt      = strb.fire ? CW'($countones(dstEn)) : '0;
  end
endmodule

// File: rtl/rename_freelist.sv
module rename_freelist import rename_pkg::*; #(
  parameter int NUM_LOG  = 8,
  parameter int NUM_PHYS = 16,
  parameter int GROUP    = 3,
  parameter int PW       = 4,
  parameter int CW       = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  renStrobe_t                strb,
  input  logic [CW-1:0]             allocCnt,
  input  logic [PW-1:0]             freeTag,
  output logic [GROUP-1:0][PW-1:0]  headTags,
  output logic [CW-1:0]             freeCount
);
  localparam int INIT_FREE = NUM_PHYS - NUM_LOG;

  logic [NUM_PHYS-1:0][PW-1:0] ring;
  logic [PW-1:0] headPtr;
  logic [PW-1:0] tailPtr;

  always_comb begin
    for (int k = 0; k < GROUP; k++) headTags[k] = ring[headPtr + PW'(k)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_PHYS; k++) ring[k] <= PW'(k + NUM_LOG);
      headPtr   <= '0;
      tailPtr   <= PW'(INIT_FREE);
      freeCount <= CW'(INIT_FREE);
    end else begin
      if (strb.fire) headPtr <= headPtr + PW'(allocCnt);
      if (strb.pushFree) begin
        ring[tailPtr] <= freeTag;
        tailPtr       <= tailPtr + 1'b1;
      end
      freeCount <= freeCount - allocCnt + CW'(strb.pushFree);
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeCount <= CW'(INIT_FREE));
  // R6
  fire_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.fire |-> freeCount >= CW'(GROUP));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.fire && !strb.pushFree) |=> $stable(freeCount) && $stable(headPtr));
endmodule

// File: rtl/rename_map.sv
module rename_map import rename_pkg::*; #(
  parameter int NUM_LOG = 8,
  parameter int GROUP   = 3,
  parameter int LW      = 3,
  parameter int PW      = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  renStrobe_t                strb,
  input  logic [GROUP-1:0]          dstEn,
  input  logic [GROUP-1:0][LW-1:0]  dstL,
  input  logic [GROUP-1:0][LW-1:0]  srcAL,
  input  logic [GROUP-1:0][LW-1:0]  srcBL,
  input  logic [GROUP-1:0][PW-1:0]  headTags,
  output logic [GROUP-1:0][PW-1:0]  srcAP,
  output logic [GROUP-1:0][PW-1:0]  srcBP,
  output logic [GROUP-1:0][PW-1:0]  newTag,
  output logic [GROUP-1:0][PW-1:0]  oldP
);
  logic [NUM_LOG-1:0][PW-1:0] mapTab;

  // New tags: walk the free-list head in slot order, skipping slots without a destination
  always_comb begin
    int used;
    used = 0;
    for (int i = 0; i < GROUP; i++) begin
      newTag[i] = '0;
      for (int k = 0; k < GROUP; k++) if (k == used) newTag[i] = headTags[k];
      if (dstEn[i]) used = used + 1;
    end
  end

  // Lookups with in-group forwarding; the youngest earlier writer wins
  always_comb begin
    for (int i = 0; i < GROUP; i++) begin
      srcAP[i] = mapTab[srcAL[i]];
      srcBP[i] = mapTab[srcBL[i]];
      oldP[i]  = mapTab[dstL[i]];
      for (int j = 0; j < i; j++) begin
        if (dstEn[j] && dstL[j] == srcAL[i]) srcAP[i] = newTag[j];
        if (dstEn[j] && dstL[j] == srcBL[i]) srcBP[i] = newTag[j];
        if (dstEn[j] && dstL[j] == dstL[i])  oldP[i]  = newTag[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_LOG; k++) mapTab[k] <= PW'(k);
    end else if (strb.fire) begin
      for (int i = 0; i < GROUP; i++)
        if (dstEn[i]) mapTab[dstL[i]] <= newTag[i];
    end
  end

  // R2
  for (genvar i = 0; i < GROUP; i++) begin : g_uniq
    for (genvar j = i + 1; j < GROUP; j++) begin : g_pair
      tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.fire && dstEn[i] && dstEn[j]) |-> newTag[i] != newTag[j]);
    end
  end
  // R7
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.fire || dstEn == '0) |=> $stable(mapTab));
  // R5
  youngest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.fire && dstEn[GROUP-1]) |=> mapTab[$past(dstL[GROUP-1])] == $past(newTag[GROUP-1]));
endmodule

// File: rtl/reg_renamer.sv
module reg_renamer import rename_pkg::*; #(
  parameter int NUM_LOG  = 8,
  parameter int NUM_PHYS = 16,
  parameter int GROUP    = 3,
  parameter int LW       = $clog2(NUM_LOG),
  parameter int PW       = $clog2(NUM_PHYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inValid,
  input  logic [GROUP-1:0]      dstEn,
  input  logic [GROUP*LW-1:0]   dstLog,
  input  logic [GROUP*LW-1:0]   srcALog,
  input  logic [GROUP*LW-1:0]   srcBLog,
  input  logic                  freeEn,
  input  logic [PW-1:0]         freeTag,
  output logic                  accept,
  output logic [GROUP*PW-1:0]   srcAPhys,
  output logic [GROUP*PW-1:0]   srcBPhys,
  output logic [GROUP*PW-1:0]   dstPhys,
  output logic [GROUP*PW-1:0]   oldPhys
);
  localparam int CW = PW + 1;

  renStrobe_t                strb;
  logic [CW-1:0]             allocCnt;
  logic [CW-1:0]             freeCount;
  logic [GROUP-1:0][PW-1:0]  headTags;

  rename_ctrl #(.GROUP(GROUP), .CW(CW)) u_ctrl (
    .inValid(inValid), .freeEn(freeEn), .dstEn(dstEn), .freeCount(freeCount),
    .strb(strb), .allocCnt(allocCnt));

  rename_freelist #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .GROUP(GROUP), .PW(PW), .CW(CW)) u_free (
    .clk(clk), .rst_n(rst_n), .strb(strb), .allocCnt(allocCnt), .freeTag(freeTag),
    .headTags(headTags), .freeCount(freeCount));

  rename_map #(.NUM_LOG(NUM_LOG), .GROUP(GROUP), .LW(LW), .PW(PW)) u_map (
    .clk(clk), .rst_n(rst_n), .strb(strb), .dstEn(dstEn), .dstL(dstLog),
    .srcAL(srcALog), .srcBL(srcBLog), .headTags(headTags),
    .srcAP(srcAPhys), .srcBP(srcBPhys), .newTag(dstPhys), .oldP(oldPhys));

  assign accept = strb.fire;
endmodule

// File: tb/sim_reg_renamer.sv
`timescale 1ns/1ps
module sim_reg_renamer;
  localparam int NL = 8, NP = 16, G = 3, LW = 3, PW = 4;

  logic clk = 0, rst_n = 0, inValid = 0, freeEn = 0;
  logic [G-1:0] dstEn = '0;
  logic [G*LW-1:0] dstLog = '0, srcALog = '0, srcBLog = '0;
  logic [PW-1:0] freeTag = '0;
  logic accept;
  logic [G*PW-1:0] srcAPhys, srcBPhys, dstPhys, oldPhys;

  always #2 clk = ~clk;

  reg_renamer u0 (.clk(clk), .rst_n(rst_n), .inValid(inValid), .dstEn(dstEn),
    .dstLog(dstLog), .srcALog(srcALog), .srcBLog(srcBLog), .freeEn(freeEn),
    .freeTag(freeTag), .accept(accept), .srcAPhys(srcAPhys), .srcBPhys(srcBPhys),
    .dstPhys(dstPhys), .oldPhys(oldPhys));

  int errors = 0, checks = 0;
  int mmap[NL];
  int fq[$];
  int pend[$];
  bit freeOn = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gA(int i); return int'(srcAPhys[i*PW +: PW]); endfunction
  function automatic int gB(int i); return int'(srcBPhys[i*PW +: PW]); endfunction
  function automatic int gD(int i); return int'(dstPhys[i*PW +: PW]); endfunction
  function automatic int gO(int i); return int'(oldPhys[i*PW +: PW]); endfunction

  // One cycle: drive after the falling edge, check, then advance the model at the rising edge
  task automatic step(input bit v, input bit [G-1:0] en, input int d[G], input int a[G], input int b[G]);
    int newT[G], idx, ea, eb, eo;
    bit expAcc, doFree;
    int fTag;
    @(negedge clk);
    inValid = v; dstEn = en;
    for (int i = 0; i < G; i++) begin
      dstLog[i*LW +: LW] = LW'(d[i]); srcALog[i*LW +: LW] = LW'(a[i]); srcBLog[i*LW +: LW] = LW'(b[i]);
    end
    doFree = freeOn && pend.size() > 0;
    fTag = doFree ? pend[0] : 0;
    freeEn = doFree; freeTag = PW'(fTag);
    expAcc = v && fq.size() >= G;
    idx = 0;
    for (int i = 0; i < G; i++) begin
      newT[i] = -1;
      if (en[i]) begin newT[i] = (idx < fq.size()) ? fq[idx] : -1; idx++; end
    end
    #1;
    chk(accept == expAcc, "R1/R6 accept", int'(accept), int'(expAcc));
    if (expAcc) begin
      for (int i = 0; i < G; i++) begin
        ea = mmap[a[i]]; eb = mmap[b[i]]; eo = mmap[d[i]];
        for (int j = 0; j < i; j++) if (en[j]) begin
          if (d[j] == a[i]) ea = newT[j];
          if (d[j] == b[i]) eb = newT[j];
          if (d[j] == d[i]) eo = newT[j];
        end
        chk(gA(i) == ea, "R3 srcA", gA(i), ea);
        chk(gB(i) == eb, "R3 srcB", gB(i), eb);
        if (en[i]) begin
          chk(gD(i) == newT[i], "R2 dst", gD(i), newT[i]);
          chk(gO(i) == eo, "R4 old", gO(i), eo);
        end
      end
    end else begin
      chk(gA(0) == mmap[a[0]], "R6 table lookup during stall", gA(0), mmap[a[0]]);
    end
    @(posedge clk);
    if (expAcc) begin
      for (int i = 0; i < G; i++) if (en[i]) begin
        pend.push_back(mmap[d[i]]);
        mmap[d[i]] = newT[i];
        void'(fq.pop_front());
      end
    end
    if (doFree) begin fq.push_back(fTag); void'(pend.pop_front()); end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d[G], a[G], b[G];
    int s;
    for (int k = 0; k < NL; k++) mmap[k] = k;
    for (int k = NL; k < NP; k++) fq.push_back(k);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R8: identity map, no destinations (R7: table must stay put)
    for (int g = 0; g < 3; g++) begin
      d = '{0, 0, 0}; a = '{(3*g) % NL, (3*g+1) % NL, (3*g+2) % NL}; b = '{7, 6, 5};
      step(1, 3'b000, d, a, b);
      for (int i = 0; i < G; i++) chk(gA(i) == a[i], "R8 reset identity", gA(i), a[i]);
    end

    // R3 chain: three writes of logical 1, each reading it
    d = '{1, 1, 1}; a = '{1, 1, 1}; b = '{1, 1, 1};
    step(1, 3'b111, d, a, b);
    chk(gA(0) == 1 && gA(1) == 8 && gA(2) == 9, "R3 chain sources", gA(1), 8);
    chk(gD(0) == 8 && gD(1) == 9 && gD(2) == 10, "R8 free order / R2 chain dsts", gD(2), 10);
    // R5: logical 1 now maps to the youngest tag
    d = '{0, 0, 0}; a = '{1, 0, 0}; b = '{0, 0, 0};
    step(1, 3'b000, d, a, b);
    chk(gA(0) == 10, "R5 youngest writer", gA(0), 10);

    // R7: middle slot has no destination and takes no tag
    d = '{2, 2, 2}; a = '{0, 2, 2}; b = '{0, 0, 0};
    step(1, 3'b101, d, a, b);
    chk(gD(0) == 11 && gD(2) == 12, "R7 skipped slot takes no tag", gD(2), 12);
    chk(gA(1) == 11, "R3 forward past empty slot", gA(1), 11);

    // Drain: 13,14,15 left, take them all, then the next group stalls
    d = '{3, 4, 5}; a = '{3, 4, 5}; b = '{0, 0, 0};
    step(1, 3'b111, d, a, b);
    d = '{6, 6, 6}; a = '{6, 3, 1}; b = '{0, 0, 0};
    step(1, 3'b111, d, a, b);
    chk(accept == 0, "R6 stall with empty list", int'(accept), 0);
    // R6: table unchanged after the stall
    d = '{0, 0, 0}; a = '{6, 3, 2}; b = '{1, 4, 5};
    step(1, 3'b000, d, a, b);
    chk(gA(0) == 6, "R6 no table update on stall", gA(0), 6);
    chk(gA(1) == 13, "R6 earlier mapping kept", gA(1), 13);

    // R9: free three tags (1, 8, 9 in order), then they are reused in that order
    freeOn = 1;
    d = '{0, 0, 0}; a = '{0, 0, 0}; b = '{0, 0, 0};
    repeat (3) step(0, 3'b000, d, a, b);
    freeOn = 0;
    d = '{0, 1, 2}; a = '{0, 1, 2}; b = '{0, 0, 0};
    step(1, 3'b111, d, a, b);
    chk(gD(0) == 1 && gD(1) == 8 && gD(2) == 9, "R9 freed tags reused FIFO", gD(0), 1);

    // Sweep: pseudo-random groups with continuous frees, all fields against the model
    freeOn = 1;
    s = 32'h1ACE5;
    for (int n = 0; n < 600; n++) begin
      bit [G-1:0] en;
      for (int i = 0; i < G; i++) begin
        s = s * 1103515245 + 12345;
        d[i] = (s >>> 8) & 7; a[i] = (s >>> 12) & 7; b[i] = (s >>> 16) & 7;
        en[i] = ((s >>> 20) & 3) != 0;
      end
      step(((s >>> 24) & 7) != 0, en, d, a, b);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule